// File: doc/BRIEF.md
# Peak-Current PWM Generator with Cycle-by-Cycle Trip

This block produces one PWM output for peak-current-mode power stages. An up-counter runs from zero to a programmable terminal value and then returns to zero. The output rises at the start of every period. It falls when the counter reaches a maximum compare value, or earlier when a trip from the current comparator arrives. A trip means that the measured current has reached the reference.

The trip input is asynchronous. It passes through a synchronizer and then a majority-vote glitch filter. A filtered trip is ignored during a programmable leading-edge blanking window, which suppresses the switching spike at turn-on. A trip holds the output low only for the rest of the current period. Each period start releases it again. A one-clock sync pulse marks counter zero. A sticky flag shows that a trip, and not the compare, ended the on-time of the running period.

Top module: `pcm_pwm`

## Requirements
- R1: While `rst` is high, `pwm_o`, `sync_o` and `trip_flag_o` are low. The first clock edge after release sees a counter value of zero.
- R2: The counter steps by one each clock and returns to zero after the edge at which it equals `period_i`. `pwm_o` goes high in the cycle that follows every counter-zero edge.
- R3: With no trip, `pwm_o` goes low in the cycle after the edge at which the counter (nonzero) is at or above `cmp_max_i`. If `cmp_max_i` exceeds `period_i`, the output stays high continuously.
- R4: A filtered trip has no effect while the counter is below `blank_len_i`.
- R5: An accepted trip drives `pwm_o` low one cycle later, and the output stays low until the next period start, even when the trip persists.
- R6: `trip_flag_o` goes high together with a trip turn-off that ends the on-time. It returns low in the same cycle that `sync_o` is high.
- R7: `sync_o` is a pulse lasting one cycle, in the cycle after each edge at which the counter is zero.
- R8: A level change on `trip_i` that is held for at least FILT_WIN clocks is used by the decision at the edge SYNC_STAGES+FILT_THRESH+1 edges after the first edge that samples it. With the defaults of 2 stages, a window of 5 and a threshold of 4, this is 7 edges.
- R9: After a quiet input, a pulse on `trip_i` shorter than FILT_THRESH clocks never turns the output off and never sets the flag.
- R10: At counter zero the period start always wins. The output rises and the flag clears even when a filtered trip is active and `blank_len_i` is 0.
- R11: When the trip is accepted at the same edge at which the compare is reached, the compare ends the on-time and `trip_flag_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-base clock |
| rst | input | 1 | Synchronous active-high reset |
| period_i | input | CNT_W | Terminal counter value; the period is period_i+1 clocks |
| cmp_max_i | input | CNT_W | Counter value that ends the on-time if no trip comes first |
| blank_len_i | input | CNT_W | Leading-edge blanking length in counts |
| trip_i | input | 1 | Asynchronous comparator trip, high when current is at or above reference |
| pwm_o | output | 1 | PWM output |
| sync_o | output | 1 | One-clock pulse marking counter zero |
| trip_flag_o | output | 1 | High once a trip has ended the current on-time |

## Verification
Two collisions are provoked. In the first, the trip is accepted at the same edge at which the compare is reached. In the second, the filtered trip turns active at the very edge that starts a new period. In both cases the bench times the trip edge from its own counter model so that the filtered trip lands on the chosen count. The judgement for the first case is that the flag stays low while the output falls on the compare. The judgement for the second is that the output rises and the flag clears, even with no blanking, and that the trip then turns the output off one count later.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_CMP   = 2'd1,
    EV_TRIP  = 2'd2,
    EV_START = 2'd3
  } pcm_evt_e;
endpackage

// File: rtl/pcm_sync.sv
module pcm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/pcm_filter.sv
module pcm_filter #(
  parameter int WIN    = 5,
  parameter int THRESH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  localparam int CW = $clog2(WIN + 1);
  localparam int LO = WIN - THRESH;

  logic [WIN-1:0] hist;
  logic [CW-1:0]  ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < WIN; i++) ones = ones + CW'(hist[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '0;
      q_o  <= 1'b0;
    end else begin
      hist <= {hist[WIN-2:0], d_i};
      if (ones >= CW'(THRESH))  q_o <= 1'b1;
      else if (ones <= CW'(LO)) q_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pcm_timebase.sv
module pcm_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (rst)                   cnt_o <= '0;
    else if (cnt_o >= period_i) cnt_o <= '0;
    else                       cnt_o <= cnt_o + CNT_W'(1);
  end
endmodule

// File: rtl/pcm_pwm.sv
module pcm_pwm
  import pcm_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_WIN    = 5,
  parameter int FILT_THRESH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] cmp_max_i,
  input  logic [CNT_W-1:0] blank_len_i,
  input  logic             trip_i,
  output logic             pwm_o,
  output logic             sync_o,
  output logic             trip_flag_o
);
  logic [CNT_W-1:0] cnt_w;
  logic             trip_sync;
  logic             trip_filt;
  logic             cnt_zero, in_blank, cmp_hit, trip_ok;
  pcm_evt_e         evt;

  pcm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(trip_i), .q_o(trip_sync)
  );

  pcm_filter #(.WIN(FILT_WIN), .THRESH(FILT_THRESH)) u_filt (
    .clk(clk), .rst(rst), .d_i(trip_sync), .q_o(trip_filt)
  );

  pcm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst(rst), .period_i(period_i), .cnt_o(cnt_w)
  );

  always_comb begin
    cnt_zero = (cnt_w == '0);
    in_blank = cnt_zero || (cnt_w < blank_len_i);
    cmp_hit  = !cnt_zero && (cnt_w >= cmp_max_i);
    trip_ok  = trip_filt && !in_blank;
    if (cnt_zero)     evt = EV_START;
    else if (cmp_hit) evt = EV_CMP;
    else if (trip_ok) evt = EV_TRIP;
    else              evt = EV_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_o       <= 1'b0;
      sync_o      <= 1'b0;
      trip_flag_o <= 1'b0;
    end else begin
      sync_o <= cnt_zero;
      case (evt)
        EV_START: begin
          pwm_o       <= 1'b1;
          trip_flag_o <= 1'b0;
        end
        EV_CMP:  pwm_o <= 1'b0;
        EV_TRIP: begin
          if (pwm_o) trip_flag_o <= 1'b1;
          pwm_o <= 1'b0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pcm_pwm_chk.sv
module pcm_pwm_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             pwm_o,
  input logic             sync_o,
  input logic             trip_flag_o,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp_max_i,
  input logic [CNT_W-1:0] blank_len_i,
  input logic [CNT_W-1:0] period_i
);
  assert_start_high_R2: assert property (@(posedge clk) disable iff (rst)
    sync_o |-> pwm_o);

  assert_flag_clear_R6: assert property (@(posedge clk) disable iff (rst)
    sync_o |-> !trip_flag_o);

  assert_flag_low_R5: assert property (@(posedge clk) disable iff (rst)
    trip_flag_o |-> !pwm_o);

  assert_sync_single_R7: assert property (@(posedge clk) disable iff (rst)
    (sync_o && $past(period_i) != '0) |=> !sync_o);

  assert_blank_respected_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(trip_flag_o) |-> ($past(cnt) >= $past(blank_len_i)) && ($past(cnt) != '0));

  assert_cmp_fall_R3: assert property (@(posedge clk) disable iff (rst)
    ($fell(pwm_o) && !trip_flag_o) |-> ($past(cnt) >= $past(cmp_max_i)));
endmodule

bind pcm_pwm pcm_pwm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .pwm_o(pwm_o), .sync_o(sync_o),
  .trip_flag_o(trip_flag_o), .cnt(cnt_w), .cmp_max_i(cmp_max_i),
  .blank_len_i(blank_len_i), .period_i(period_i)
);

// File: tb/sim_pcm_pwm.sv
`timescale 1ns/1ps
module sim_pcm_pwm;
  localparam int CNT_W = 16;
  localparam int SYNC  = 2;
  localparam int WIN   = 5;
  localparam int TH    = 4;
  localparam int D     = SYNC + TH + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CNT_W-1:0] period_i = 16'd19;
  logic [CNT_W-1:0] cmp_max_i = 16'd12;
  logic [CNT_W-1:0] blank_len_i = 16'd4;
  logic trip_i = 1'b0;
  logic pwm_o, sync_o, trip_flag_o;

  always #5 clk = ~clk;

  pcm_pwm #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC), .FILT_WIN(WIN), .FILT_THRESH(TH)) u0 (
    .clk(clk), .rst(rst), .period_i(period_i), .cmp_max_i(cmp_max_i),
    .blank_len_i(blank_len_i), .trip_i(trip_i), .pwm_o(pwm_o),
    .sync_o(sync_o), .trip_flag_o(trip_flag_o)
  );

  typedef struct { logic pwm; logic sync; logic flag; } exp_t;
  exp_t  q[$];
  int    n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  logic  model_trip = 1'b0;
  int    mcnt = 0;
  logic [D:0] hist = '0;
  logic  m_pwm = 0, m_flag = 0;
  bit    done = 0;

  // Reference model: pushes the expected outputs after each edge
  always @(posedge clk) begin
    if (rst) begin
      mcnt = 0; hist = '0; m_pwm = 0; m_flag = 0; q.delete();
    end else begin
      logic eff, zero, blank, cmp_hit, trip_ok;
      exp_t e;
      hist    = {hist[D-1:0], model_trip};
      eff     = hist[D];
      zero    = (mcnt == 0);
      blank   = zero || (mcnt < int'(blank_len_i));
      cmp_hit = !zero && (mcnt >= int'(cmp_max_i));
      trip_ok = eff && !blank;
      e.sync  = zero;
      if (zero) begin m_pwm = 1; m_flag = 0; end
      else if (cmp_hit) m_pwm = 0;
      else if (trip_ok) begin if (m_pwm) m_flag = 1; m_pwm = 0; end
      e.pwm = m_pwm; e.flag = m_flag;
      q.push_back(e);
      mcnt = (mcnt >= int'(period_i)) ? 0 : mcnt + 1;
    end
  end

  // Monitor: compares away from the active edge
  always @(negedge clk) begin
    if (!rst && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_cmp++;
      if (pwm_o !== e.pwm || sync_o !== e.sync || trip_flag_o !== e.flag) begin
        n_bad++;
        $display("FAIL %s: pwm/sync/flag actual=%b%b%b expected=%b%b%b at %0t",
                 cur_req, pwm_o, sync_o, trip_flag_o, e.pwm, e.sync, e.flag, $time);
      end
    end
  end

  task automatic check_bit(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_cnt(input int v);
    do @(negedge clk); while (mcnt != v);
  endtask

  task automatic set_trip(input logic v);
    trip_i = v; model_trip = v;
  endtask

  initial begin
    // R1: reset state
    run(3);
    check_bit("R1 pwm", pwm_o, 1'b0);
    check_bit("R1 sync", sync_o, 1'b0);
    check_bit("R1 flag", trip_flag_o, 1'b0);
    rst = 1'b0;

    cur_req = "R2 R3 R7 no trip";
    run(60);

    cur_req = "R4 R5 R6 steady trip";
    set_trip(1); run(70);
    set_trip(0); run(30);

    cur_req = "R5 R8 mid-period trip";
    wait_cnt(1); set_trip(1); run(5); set_trip(0); run(40);

    cur_req = "R9 glitch rejected";
    wait_cnt(2); trip_i = 1'b1; run(TH - 1); trip_i = 1'b0; run(40);

    cur_req = "R11 trip meets compare";
    wait_cnt(int'(cmp_max_i) - D); set_trip(1); run(45); set_trip(0); run(20);

    cur_req = "R10 trip at period start";
    blank_len_i = 16'd0;
    wait_cnt(int'(period_i) + 1 - D); set_trip(1); run(45); set_trip(0); run(20);
    blank_len_i = 16'd4; run(20);

    cur_req = "R3 compare above period";
    cmp_max_i = 16'd25; run(50); cmp_max_i = 16'd12; run(30);

    cur_req = "R2 short period";
    period_i = 16'd7; cmp_max_i = 16'd3; run(30);
    set_trip(1); run(20); set_trip(0); run(20);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule